// File: doc/BRIEF.md
# SPWM Gate-Drive Controller for a Boost-Fed Half-Bridge

This block turns four digital words into the three switch-drive signals of a two-stage power converter. The first stage is a boost pump with one charging switch. The second is a half-bridge leg with a positive-side switch and a negative-side switch. Everything runs from a single system clock. A free-running up-counter serves as the carrier ramp, and one ramp period is one switching period. The duty word is compared against the ramp to form a base clock. Two anti-phase, non-overlapping phases come from that base clock, separated by a programmable number of dead cycles. The charging phase drives the boost switch directly.

During the non-charging phase, the sampled reference word and the sampled feedback word are each compared against the same ramp. The positive leg pulses while the ramp lies between the reference (above) and the feedback (below). The negative leg pulses while the ramp lies under both words, and only when the feedback exceeds the reference. The two leg drives are interlocked. Duty, reference and feedback are captured once per switching period, at the ramp wrap, so no comparison changes in mid-period. All three drives are registered.

Top module: `spwm_gate_ctrl`

## Requirements
- R1: The ramp counts 0, 1, … 2^CNT_W−1 and then wraps to 0. The switching period is therefore 2^CNT_W clocks, and a period with latched duty D and dead time T holds `drv_boost` high for max(0, D−T) clocks.
- R2: The base clock is high exactly while the latched duty word is strictly greater than the ramp. A duty word of 0 never charges. `drv_boost` equals the charging phase.
- R3: After each change of the base clock, both phases stay low for `dead_cycles` clocks. With a dead time of 0 they switch on the same clock. `drv_boost` is high for ramp values from `dead_cycles` through D−1.
- R4: For D>0, the non-charging phase is high for ramp values of D+`dead_cycles` and above. For D=0 it stays high once the base clock has been low for at least `dead_cycles` clocks.
- R5: `drv_leg_pos` is high exactly when the non-charging phase is high, reference > ramp, and ramp > feedback.
- R6: `drv_leg_neg` is high exactly when the non-charging phase is high, feedback > ramp, reference > ramp, and reference < feedback.
- R7: `drv_leg_pos` and `drv_leg_neg` are never high on the same clock. Neither of them is ever high on the same clock as `drv_boost`.
- R8: Every comparison that meets equality resolves low. A reference equal to the feedback drives neither leg.
- R9: Duty, reference and feedback are captured only on the clock at which the ramp wraps. A change at any other time has no effect until the next period.
- R10: The active-high synchronous reset forces all three drives low and restarts the ramp at 0. It loads duty 0 and mid-scale (2^(CNT_W−1)) reference and feedback. Each drive is registered: the value seen after a clock edge belongs to the ramp value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_word | input | CNT_W | Boost duty, compared against the ramp |
| ref_word | input | CNT_W | Sinusoidal reference sample, mid-scale offset |
| fb_word | input | CNT_W | Output feedback sample, mid-scale offset |
| dead_cycles | input | DEAD_W | Dead time between the two phases, in clocks |
| drv_boost | output | 1 | Boost charging-switch drive |
| drv_leg_pos | output | 1 | Half-bridge positive-side drive |
| drv_leg_neg | output | 1 | Half-bridge negative-side drive |

## Verification
The bench sweeps duty values of zero, small, mid-scale and full scale against dead times of zero, short and long. This separates the strict-compare boundaries and the dead-time windows on both edges of the base clock, including the case where the base clock never rises. For each setting, reference and feedback walk a grid that puts each word below, equal to and above the other and at both rails. This tells the positive-leg window apart from the negative-leg window, and both apart from the tie case. Some periods also rewrite the input words in mid-period, which shows that capture happens only at the wrap. The per-period charge count shows that the period length and the duty-minus-dead rule hold.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    // Pair of boost phases: charging and non-charging.
    typedef struct packed {
        logic chg;
        logic dis;
    } phase_pair_t;

    // Registered drive bundle for the three switches.
    typedef struct packed {
        logic boost;
        logic pos;
        logic neg;
    } drive_t;

    // Which half of the inverter output the loop is asking for.
    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_POS  = 2'd1,
        LEG_NEG  = 2'd2
    } leg_dir_e;

    localparam drive_t DRIVE_OFF = '{boost: 1'b0, pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/spwm_ramp.sv
module spwm_ramp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] ref_in,
    input  logic [CNT_W-1:0] fb_in,
    output logic [CNT_W-1:0] ramp,
    output logic [CNT_W-1:0] duty_q,
    output logic [CNT_W-1:0] ref_q,
    output logic [CNT_W-1:0] fb_q
);
    localparam logic [CNT_W-1:0] RAMP_TOP = '1;
    localparam logic [CNT_W-1:0] MID_SCALE = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] ramp_q;
    logic             at_wrap;

    assign at_wrap = (ramp_q == RAMP_TOP);
    assign ramp    = ramp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q <= '0;
            duty_q <= '0;
            ref_q  <= MID_SCALE;
            fb_q   <= MID_SCALE;
        end else begin
            ramp_q <= ramp_q + STEP;
            if (at_wrap) begin
                duty_q <= duty_in;
                ref_q  <= ref_in;
                fb_q   <= fb_in;
            end
        end
    end

    // R1: ramp advances by one every clock and wraps modulo 2^CNT_W
    p_ramp_step_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ramp_q == $past(ramp_q) + STEP));

    // R9: captured words only move on the wrap clock
    p_hold_words_r9: assert property (@(posedge clk) disable iff (rst)
        !at_wrap |=> ($stable(duty_q) && $stable(ref_q) && $stable(fb_q)));

endmodule

// File: rtl/spwm_phase.sv
module spwm_phase
    import spwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  ramp,
    input  logic [CNT_W-1:0]  duty_q,
    input  logic [DEAD_W-1:0] dead,
    output phase_pair_t       ph
);
    localparam logic [DEAD_W-1:0] AGE_SAT = '1;
    localparam logic [DEAD_W-1:0] AGE_ONE = DEAD_W'(1);

    logic              base_clk;
    logic              base_prev_q;
    logic [DEAD_W-1:0] age_q;
    logic [DEAD_W-1:0] age_now;
    logic              settled;

    // Strict compare: equality gives low.
    assign base_clk = (duty_q > ramp);

    // Age of the current base-clock level, saturating.
    always_comb begin
        if (base_clk != base_prev_q) begin
            age_now = '0;
        end else if (age_q == AGE_SAT) begin
            age_now = AGE_SAT;
        end else begin
            age_now = age_q + AGE_ONE;
        end
    end

    assign settled = (age_now >= dead);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_prev_q <= 1'b0;
            age_q       <= AGE_SAT;
        end else begin
            base_prev_q <= base_clk;
            age_q       <= age_now;
        end
    end

    assign ph.chg = base_clk & settled;
    assign ph.dis = ~base_clk & settled;

endmodule

// File: rtl/spwm_leg.sv
module spwm_leg
    import spwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] ramp,
    input  logic [CNT_W-1:0] ref_q,
    input  logic [CNT_W-1:0] fb_q,
    input  logic             dis_phase,
    output logic             pos_drv,
    output logic             neg_drv
);
    logic     ref_over_ramp;
    logic     ramp_over_fb;
    logic     fb_over_ramp;
    logic     pos_window;
    logic     neg_window;
    logic     pos_req;
    logic     neg_req;
    leg_dir_e dir;

    // Paired ramp comparisons, ties resolve low.
    assign ref_over_ramp = (ref_q > ramp);
    assign ramp_over_fb  = (ramp > fb_q);
    assign fb_over_ramp  = (fb_q > ramp);

    assign pos_window = ref_over_ramp & ramp_over_fb;
    assign neg_window = fb_over_ramp & ref_over_ramp;

    always_comb begin
        if (ref_q > fb_q) begin
            dir = LEG_POS;
        end else if (ref_q < fb_q) begin
            dir = LEG_NEG;
        end else begin
            dir = LEG_IDLE;
        end
    end

    // Only in the non-charging phase, and only on the requested side.
    assign pos_req = dis_phase & pos_window & (dir == LEG_POS);
    assign neg_req = dis_phase & neg_window & (dir == LEG_NEG);

    // Interlock: a simultaneous request releases both sides.
    assign pos_drv = pos_req & ~neg_req;
    assign neg_drv = neg_req & ~pos_req;

endmodule

// File: rtl/spwm_gate_ctrl.sv
module spwm_gate_ctrl
    import spwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  duty_word,
    input  logic [CNT_W-1:0]  ref_word,
    input  logic [CNT_W-1:0]  fb_word,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              drv_boost,
    output logic              drv_leg_pos,
    output logic              drv_leg_neg
);
    logic [CNT_W-1:0] ramp;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] fb_q;
    phase_pair_t      ph;
    logic             pos_c;
    logic             neg_c;
    drive_t           drive_q;
    logic             dis_q;

    spwm_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .duty_in (duty_word),
        .ref_in  (ref_word),
        .fb_in   (fb_word),
        .ramp    (ramp),
        .duty_q  (duty_q),
        .ref_q   (ref_q),
        .fb_q    (fb_q)
    );

    spwm_phase #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .ramp   (ramp),
        .duty_q (duty_q),
        .dead   (dead_cycles),
        .ph     (ph)
    );

    spwm_leg #(.CNT_W(CNT_W)) u_leg (
        .ramp      (ramp),
        .ref_q     (ref_q),
        .fb_q      (fb_q),
        .dis_phase (ph.dis),
        .pos_drv   (pos_c),
        .neg_drv   (neg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= DRIVE_OFF;
            dis_q   <= 1'b0;
        end else begin
            drive_q <= '{boost: ph.chg, pos: pos_c, neg: neg_c};
            dis_q   <= ph.dis;
        end
    end

    assign drv_boost   = drive_q.boost;
    assign drv_leg_pos = drive_q.pos;
    assign drv_leg_neg = drive_q.neg;

    // R10: reset clears every drive on the following clock
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!drv_boost && !drv_leg_pos && !drv_leg_neg));

    // R7: the two leg drives never overlap
    p_interlock_r7: assert property (@(posedge clk) disable iff (rst)
        !(drv_leg_pos && drv_leg_neg));

    // R7: no leg conduction while the boost switch is charging
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        !(drv_boost && (drv_leg_pos || drv_leg_neg)));

    // R3: back-to-back phases only when the dead time is zero
    p_dead_gap_r3: assert property (@(posedge clk) disable iff (rst)
        ((dis_q && $past(drv_boost)) || (drv_boost && $past(dis_q)))
        |-> ($past(dead_cycles) == '0));

endmodule

// File: tb/spwm_gate_ctrl_tb.sv
`timescale 1ns/1ps
module spwm_gate_ctrl_tb_top;

    localparam int CW   = 4;
    localparam int DW   = 3;
    localparam int RTOP = (1 << CW) - 1;
    localparam int PER  = 1 << CW;
    localparam int ASAT = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] duty_word = '0;
    logic [CW-1:0] ref_word  = '0;
    logic [CW-1:0] fb_word   = '0;
    logic [DW-1:0] dead_cycles = '0;
    logic          drv_boost;
    logic          drv_leg_pos;
    logic          drv_leg_neg;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spwm_gate_ctrl #(.CNT_W(CW), .DEAD_W(DW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .duty_word   (duty_word),
        .ref_word    (ref_word),
        .fb_word     (fb_word),
        .dead_cycles (dead_cycles),
        .drv_boost   (drv_boost),
        .drv_leg_pos (drv_leg_pos),
        .drv_leg_neg (drv_leg_neg)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b (duty=%0d dead=%0d ref=%0d fb=%0d)",
                     req, what, got, exp, duty_word, dead_cycles, ref_word, fb_word);
        end
    endtask

    function automatic int pick_duty(int i);
        case (i)
            0: return 0;
            1: return 3;
            2: return 8;
            default: return 15;
        endcase
    endfunction

    function automatic int pick_dead(int i);
        case (i)
            0: return 0;
            1: return 2;
            default: return 5;
        endcase
    endfunction

    function automatic int pick_word(int i);
        case (i)
            0: return 0;
            1: return 4;
            2: return 8;
            3: return 12;
            default: return 15;
        endcase
    endfunction

    // Non-charging phase at ramp r: R4 (dw = duty latched in the previous period)
    function automatic bit exp_dis(int r, int d, int dt, int dw);
        int age;
        if (d > 0) begin
            if (r < d) return 1'b0;
            age = r - d;
        end else if (dw > 0) begin
            age = RTOP - dw + 1 + r;
        end else begin
            age = ASAT;
        end
        if (age > ASAT) age = ASAT;
        return age >= dt;
    endfunction

    task automatic set_words(input int d, input int dt, input int rf, input int fb);
        duty_word   = CW'(d);
        dead_cycles = DW'(dt);
        ref_word    = CW'(rf);
        fb_word     = CW'(fb);
    endtask

    // Check one full period whose latched words are (d, rf, fb); scr rewrites inputs mid-period
    task automatic check_period(input int d, input int dt, input int rf, input int fb,
                                input int dw, input bit scr);
        int  n_chg = 0;
        bit  e_chg, e_dis, e_pos, e_neg;
        for (int j = 0; j < PER; j++) begin
            tick();
            e_chg = (d > 0) && (j < d) && (j >= dt);
            e_dis = exp_dis(j, d, dt, dw);
            e_pos = e_dis && (rf > j) && (j > fb);
            e_neg = e_dis && (fb > j) && (rf > j) && (rf < fb);
            if (scr) begin
                chk(drv_boost,   e_chg, "R9", "boost with mid-period rewrite");
                chk(drv_leg_pos, e_pos, "R9", "pos with mid-period rewrite");
                chk(drv_leg_neg, e_neg, "R9", "neg with mid-period rewrite");
            end else begin
                chk(drv_boost,   e_chg, "R2/R3", "boost drive");
                chk(drv_leg_pos, e_pos, "R5/R4", "positive leg");
                chk(drv_leg_neg, e_neg, "R6/R4", "negative leg");
            end
            chk(!(drv_leg_pos && drv_leg_neg), 1'b1, "R7", "leg interlock");
            chk(!(drv_boost && (drv_leg_pos || drv_leg_neg)), 1'b1, "R7", "boost vs leg overlap");
            if (rf == fb) chk(drv_leg_pos || drv_leg_neg, 1'b0, "R8", "tie drives no leg");
            if (drv_boost === 1'b1) n_chg++;
            if (scr && j == 7) begin
                set_words((d + 5) % PER, dt, RTOP - rf, RTOP - fb);
            end
        end
        n_run++;
        if (n_chg != ((d > dt) ? d - dt : 0)) begin
            n_fail++;
            $display("FAIL R1 charge count per period: got %0d expected %0d (duty=%0d dead=%0d)",
                     n_chg, (d > dt) ? d - dt : 0, d, dt);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int prev_duty;
        int cfg;
        int d, dt, rf, fb;
        bit scr;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R10: drives low straight out of reset
        chk(drv_boost,   1'b0, "R10", "boost after reset");
        chk(drv_leg_pos, 1'b0, "R10", "pos after reset");
        chk(drv_leg_neg, 1'b0, "R10", "neg after reset");

        prev_duty = 0;
        cfg = 0;
        for (int di = 0; di < 4; di++) begin
            for (int ti = 0; ti < 3; ti++) begin
                for (int ri = 0; ri < 5; ri++) begin
                    for (int fi = 0; fi < 5; fi++) begin
                        d   = pick_duty(di);
                        dt  = pick_dead(ti);
                        rf  = pick_word(ri);
                        fb  = pick_word(fi);
                        scr = (cfg % 7) == 3;
                        set_words(d, dt, rf, fb);
                        if (cfg == 0) begin
                            // R10: first period runs on reset words (duty 0, mid-scale pair)
                            for (int j = 0; j < PER; j++) begin
                                tick();
                                chk(drv_boost,   1'b0, "R10", "boost in first period");
                                chk(drv_leg_pos, 1'b0, "R10", "pos in first period");
                                chk(drv_leg_neg, 1'b0, "R10", "neg in first period");
                            end
                        end else begin
                            repeat (PER) tick();
                        end
                        check_period(d, dt, rf, fb, prev_duty, scr);
                        prev_duty = scr ? (d + 5) % PER : d;
                        cfg++;
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule